// File: doc/BRIEF.md
# Temperature-Indexed DAC Lookup Controller

This block turns a signed fixed-point temperature reading into a setting code for a digital-to-analog converter. Each time a new sample arrives with its strobe, the block maps the temperature onto a row of a small internal table. The table has one row per 2 °C band from −40 °C up to +102 °C. The block then registers both the row number and the code held in that row, after an optional inversion and an enable gate. Between strobes the index and the output code hold their values.

The table is filled by byte writes. Each row takes two byte addresses: the even address carries the two most significant code bits and the odd address carries the low eight bits. The registered row number serves as a readable status value. The higher-level logic that owns the sensor, the converter and any serial access sits outside this block.

Top module: `thermal_lut_dac`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), index_q and dac_code are 0 and every table row holds 0.
- R2: On a clock edge with temp_valid high, index_q becomes floor((T + 40) / 2). T is temp_sample read as two's complement with 8 fraction bits, in °C. The 16-bit word puts the sign and the integer bits in bits 15:8 and the fraction in bits 7:0.
- R3: A temperature below −40 °C gives index 0.
- R4: A temperature of 104 °C or more gives index 71, the last row, so index_q never exceeds 71.
- R5: A write with wr_en high to byte address 2·i (i < 72) stores wr_data[1:0] as bits 9:8 of row i. A write to address 2·i+1 stores wr_data[7:0] as bits 7:0 of row i. Other bits of the row are kept.
- R6: Writes to byte addresses 144 and above change no table row.
- R7: On a strobe, dac_code takes the content of the selected row. Without a strobe, index_q and dac_code hold their values, even when table rows, chan_en or invert change.
- R8: When invert is high at the strobe and chan_en is high, dac_code is the bitwise complement, over 10 bits, of the selected row.
- R9: When chan_en is low at the strobe, dac_code is 0, whatever the value of invert.
- R10: When a strobe and a table write fall on the same edge, the lookup uses the row content from before the write. The written value first shows at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_valid | input | 1 | New-sample strobe |
| temp_sample | input | 16 | Signed 8.8 temperature in °C |
| wr_en | input | 1 | Table byte write enable |
| wr_addr | input | 8 | Table byte address |
| wr_data | input | 8 | Table byte data |
| chan_en | input | 1 | Output enable, sampled at the strobe |
| invert | input | 1 | Output polarity, sampled at the strobe |
| index_q | output | 8 | Registered table index |
| dac_code | output | 10 | Registered converter code |

## Verification
A sample strobe and a table byte write can land on the same clock edge. The bench provokes this by raising temp_valid and wr_en in the same cycle, with the write aimed at the row the new temperature selects. The bench judges the result at two points. It expects dac_code to show the old row content right after that edge, and it expects the new content only after a later strobe to the same temperature. A second case writes the selected row between strobes, and the bench confirms that dac_code does not move.

// File: rtl/thermal_lut_pkg.sv
// Package: shared types for the temperature lookup controller.
// Assumes: nothing beyond standard SystemVerilog.
package thermal_lut_pkg;

    // Output shaping controls captured with each sample.
    typedef struct packed {
        logic enable;
        logic invert;
    } shape_cfg_t;

endpackage

// File: rtl/temp_index_calc.sv
// Module: temp_index_calc
// Maps a signed 8.8 temperature onto a table row: floor((T - T_LOW) / 2^STEP_LOG2),
// clamped to [0, N_ENTRY-1]. Purely combinational.
// Assumes: T_LOW is a whole number of degrees; the temperature word has 8 fraction bits.
module temp_index_calc #(
    parameter int T_LOW     = -40,
    parameter int STEP_LOG2 = 1,
    parameter int N_ENTRY   = 72,
    parameter int IDX_W     = 8,
    parameter int TEMP_W    = 16,
    parameter int FRAC_W    = 8
) (
    input  logic [TEMP_W-1:0] temp,
    output logic [IDX_W-1:0]  idx
);
    localparam int OFS_W = TEMP_W + 2;
    localparam int SHIFT = FRAC_W + STEP_LOG2;
    localparam logic signed [OFS_W-1:0] LOW_FIX = OFS_W'(T_LOW * (2 ** FRAC_W));
    localparam logic [OFS_W-1:0] LAST_ROW = OFS_W'(N_ENTRY - 1);

    logic signed [OFS_W-1:0] offs;
    logic        [OFS_W-1:0] steps;

    // Offset the reading to the window base and convert to whole steps.
    always_comb begin
        offs  = $signed({{2{temp[TEMP_W-1]}}, temp}) - LOW_FIX;
        steps = offs >>> SHIFT;
    end

    // Clamp below the window to row 0 and above it to the last row.
    always_comb begin
        if (offs < 0)
            idx = '0;
        else if (steps > LAST_ROW)
            idx = IDX_W'(N_ENTRY - 1);
        else
            idx = steps[IDX_W-1:0];
    end
endmodule

// File: rtl/lut_bank.sv
// Module: lut_bank
// Register table of N_ENTRY codes of DAC_W bits, loaded two bytes per row
// (even address = upper bits, odd address = lower 8 bits), read combinationally.
// Assumes: 9 <= DAC_W <= 16 and 2*N_ENTRY fits in ADDR_W bits.
module lut_bank #(
    parameter int N_ENTRY = 72,
    parameter int DAC_W   = 10,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DAC_W-1:0]  rd_code
);
    localparam int HI_W  = DAC_W - 8;
    localparam int SEL_W = $clog2(N_ENTRY);
    localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(2 * N_ENTRY);

    logic [N_ENTRY-1:0][DAC_W-1:0] mem;

    generate
        for (genvar g = 0; g < N_ENTRY; g++) begin : g_row
            // Store one row, upper and lower parts written separately.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(2 * g)) begin
                    mem[g][DAC_W-1:8] <= wr_data[HI_W-1:0];
                end else if (wr_en && wr_addr == ADDR_W'(2 * g + 1)) begin
                    mem[g][7:0] <= wr_data;
                end
            end
        end
    endgenerate

    // Read the addressed row; indices past the table read zero.
    always_comb begin
        if (rd_idx < IDX_W'(N_ENTRY))
            rd_code = mem[rd_idx[SEL_W-1:0]];
        else
            rd_code = '0;
    end

    logic [SEL_W-1:0] wr_row;
    assign wr_row = wr_addr[SEL_W:1];

    p_ignore_high_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_LIM) |=> $stable(mem));

    p_low_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0] && wr_addr < ADDR_LIM)
        |=> mem[$past(wr_row)][7:0] == $past(wr_data));
endmodule

// File: rtl/dac_shaper.sv
// Module: dac_shaper
// Applies the enable gate and optional bitwise inversion to a table code.
// Assumes: disable wins over inversion.
module dac_shaper
    import thermal_lut_pkg::*;
#(
    parameter int DAC_W = 10
) (
    input  logic [DAC_W-1:0] code_in,
    input  shape_cfg_t       cfg,
    output logic [DAC_W-1:0] code_out
);
    // Gate first, then choose polarity.
    always_comb begin
        if (!cfg.enable)
            code_out = '0;
        else if (cfg.invert)
            code_out = ~code_in;
        else
            code_out = code_in;
    end
endmodule

// File: rtl/thermal_lut_dac.sv
// Module: thermal_lut_dac
// Top of the temperature-indexed lookup controller. On each sample strobe it
// registers the computed row index and the shaped code of that row.
// Assumes: synchronous active-low reset; table writes and strobes may coincide,
// in which case the lookup sees the pre-write row.
module thermal_lut_dac
    import thermal_lut_pkg::*;
#(
    parameter int N_ENTRY   = 72,
    parameter int DAC_W     = 10,
    parameter int T_LOW     = -40,
    parameter int STEP_LOG2 = 1,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int TEMP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_sample,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              chan_en,
    input  logic              invert,
    output logic [IDX_W-1:0]  index_q,
    output logic [DAC_W-1:0]  dac_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRY - 1);

    logic [IDX_W-1:0] idx_next;
    logic [DAC_W-1:0] row_code;
    logic [DAC_W-1:0] shaped;
    shape_cfg_t       cfg;

    assign cfg = '{enable: chan_en, invert: invert};

    temp_index_calc #(
        .T_LOW(T_LOW), .STEP_LOG2(STEP_LOG2), .N_ENTRY(N_ENTRY),
        .IDX_W(IDX_W), .TEMP_W(TEMP_W), .FRAC_W(8)
    ) u_index (
        .temp(temp_sample),
        .idx (idx_next)
    );

    lut_bank #(
        .N_ENTRY(N_ENTRY), .DAC_W(DAC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_idx (idx_next),
        .rd_code(row_code)
    );

    dac_shaper #(.DAC_W(DAC_W)) u_shape (
        .code_in (row_code),
        .cfg     (cfg),
        .code_out(shaped)
    );

    // Capture index and output code on each sample strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= '0;
            dac_code <= '0;
        end else if (temp_valid) begin
            index_q  <= idx_next;
            dac_code <= shaped;
        end
    end

    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        index_q <= LAST_IDX);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(temp_valid) |-> ($stable(dac_code) && $stable(index_q)));

    p_disabled_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(temp_valid) && !$past(chan_en)) |-> dac_code == '0);

    p_clamp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(temp_valid) && $signed($past(temp_sample[TEMP_W-1:8])) < $signed(8'(T_LOW)))
        |-> index_q == '0);
endmodule

// File: tb/thermal_lut_dac_test.sv
module thermal_lut_dac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [15:0] temp_sample = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        chan_en = 1'b0;
    logic        invert = 1'b0;
    logic [7:0]  index_q;
    logic [9:0]  dac_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int tab [72];

    always #2 clk = ~clk;

    thermal_lut_dac uut (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_sample(temp_sample),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_en(chan_en), .invert(invert), .index_q(index_q), .dac_code(dac_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference index from the full signed value, in 1/256 °C units.
    function automatic int ref_idx(input logic [15:0] t);
        int v, q;
        v = int'($signed(t));
        if (v < -10240) return 0;
        q = (v + 10240) / 512;
        return (q > 71) ? 71 : q;
    endfunction

    function automatic int ref_dac(input int row, input bit en, input bit inv);
        if (!en) return 0;
        return inv ? ((~tab[row]) & 1023) : tab[row];
    endfunction

    task automatic wr_byte(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] t, input bit en, input bit inv);
        @(negedge clk);
        temp_valid = 1'b1; temp_sample = t; chan_en = en; invert = inv;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic sweep_check(input bit en, input bit inv, input string req);
        for (int r = 0; r < 72; r++) begin
            logic [15:0] t;
            t = 16'((r * 2 - 40) * 256);
            strobe(t, en, inv);
            check(req, int'(index_q), r);
            check(req, int'(dac_code), ref_dac(r, en, inv));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 72; r++) tab[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and empty table
        check("R1", int'(index_q), 0);
        check("R1", int'(dac_code), 0);
        strobe(16'(25 * 256), 1'b1, 1'b0);
        check("R1", int'(dac_code), 0);

        // R5: load every row through both byte addresses
        for (int r = 0; r < 72; r++) begin
            tab[r] = (r * 37 + 5) & 1023;
            wr_byte(2 * r, (tab[r] >> 8) | 8'hFC);
            wr_byte(2 * r + 1, tab[r] & 255);
        end
        sweep_check(1'b1, 1'b0, "R5");

        // R2/R3/R4: every integer byte with several fraction values
        for (int hi = -128; hi < 128; hi++) begin
            for (int f = 0; f < 3; f++) begin
                logic [15:0] t;
                int e;
                t = {8'(hi), (f == 0) ? 8'h00 : (f == 1) ? 8'h80 : 8'hFF};
                e = ref_idx(t);
                strobe(t, 1'b1, 1'b0);
                if (hi < -40)      check("R3", int'(index_q), e);
                else if (hi > 103) check("R4", int'(index_q), e);
                else               check("R2", int'(index_q), e);
                check("R7", int'(dac_code), tab[e]);
            end
        end

        // R8: inverted polarity; R9: disabled with either polarity
        sweep_check(1'b1, 1'b1, "R8");
        sweep_check(1'b0, 1'b1, "R9");
        sweep_check(1'b0, 1'b0, "R9");

        // R6: writes above the table leave every row unchanged
        for (int a = 144; a < 256; a++) wr_byte(a, 8'hA5);
        sweep_check(1'b1, 1'b0, "R6");

        // R7: hold between strobes despite table and control changes
        strobe(16'(10 * 256), 1'b1, 1'b0);
        check("R7", int'(dac_code), tab[25]);
        tab[25] = 10'h2C3;
        wr_byte(50, 2);
        wr_byte(51, 8'hC3);
        @(negedge clk);
        temp_sample = 16'(90 * 256); invert = 1'b1; chan_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R7", int'(dac_code), (25 * 37 + 5) & 1023);
        check("R7", int'(index_q), 25);
        strobe(16'(10 * 256), 1'b1, 1'b0);
        check("R7", int'(dac_code), tab[25]);

        // R10: strobe and write to the selected row on the same edge
        @(negedge clk);
        temp_valid = 1'b1; temp_sample = 16'(-20 * 256); chan_en = 1'b1; invert = 1'b0;
        wr_en = 1'b1; wr_addr = 8'd21; wr_data = 8'h5A;
        @(negedge clk);
        temp_valid = 1'b0; wr_en = 1'b0;
        check("R10", int'(index_q), 10);
        check("R10", int'(dac_code), tab[10]);
        tab[10] = (tab[10] & 10'h300) | 8'h5A;
        strobe(16'(-20 * 256), 1'b1, 1'b0);
        check("R10", int'(dac_code), tab[10]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule